// File: doc/BRIEF.md
# Power Button Event Controller

This block turns a raw, active-low push-button line into power-management events for the platform. It first filters the line against contact bounce and reports the filtered level. While the platform is running, a press sets a sticky status bit. That bit, combined with the enable controls, drives either a system-management interrupt request or a system-control interrupt request. While the platform is asleep or soft-off, a press instead produces a one-cycle wake request. With mechanical power removed, the press is not seen at all.

A long, continuous hold while running produces a one-cycle forced soft-off request. This request needs no acknowledgement from any other part of the system. The block also honours a minimum-off stretch window supplied by the power sequencer. During that window, presses do not wake the system and the hold timer is kept cleared. When the window closes with the button still held, the wake is delivered at that point.

Time is measured in ticks of a 1 ms strobe. Parameters set both the filter length and the hold length, so simulation can use short values.

Top module: `pwrkey_evt_ctl`

## Requirements
- R1: The filtered level changes only after the synchronised raw input has held its new value for DEB_MS consecutive ms ticks. A shorter excursion has no effect on the level, the status bit or any request.
- R2: `btn_level` is 1 while the filtered button is pressed (raw input low) and 0 while it is released.
- R3: A filtered press edge sets `press_sts` without waiting for release. This happens in the running state, and in sleep or soft-off whenever the press is accepted as a wake. A one-cycle `sts_clr` pulse clears the bit, and a set arriving in the same cycle wins.
- R4: `sci_req` equals `press_sts & evt_en & sci_sel` while `pwr_state` is running (encoding 0). `smi_req` equals `press_sts & evt_en & !sci_sel & smi_glob_en` while running. Both are 0 in every other state.
- R5: In sleep (encoding 1) or soft-off (encoding 2), with `stretch_act` low, a filtered press edge produces exactly one single-cycle `wake_req` pulse.
- R6: In mechanical-off (encoding 3), a press produces no `wake_req`, no `force_off_req`, and leaves `press_sts` unchanged.
- R7: After HOLD_MS consecutive ticks of a held button in the running state, `force_off_req` pulses for one cycle. It pulses only once per continuous hold.
- R8: The hold timer counts only in the running state. It restarts from zero on release or whenever the state leaves running, so a hold that began in sleep needs a full HOLD_MS counted from the return to running.
- R9: While `stretch_act` is high, a press gives no wake and the hold timer is held at zero. When `stretch_act` falls with the button held in sleep or soft-off, one `wake_req` pulse follows. A later override needs a fresh full HOLD_MS in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_raw_n | input | 1 | Raw button line, low = pressed, asynchronous |
| ms_tick | input | 1 | One-cycle strobe every millisecond |
| pwr_state | input | 2 | 0 running, 1 sleep S1-S4, 2 soft-off S5, 3 mechanical-off |
| sci_sel | input | 1 | 1 routes the press to the control interrupt, 0 to the management interrupt |
| evt_en | input | 1 | Button event enable |
| smi_glob_en | input | 1 | Global management-interrupt enable |
| stretch_act | input | 1 | Minimum-off stretch window active |
| sts_clr | input | 1 | Write-one-clear pulse for the status bit |
| sci_req | output | 1 | Control interrupt request (level) |
| smi_req | output | 1 | Management interrupt request (level) |
| wake_req | output | 1 | One-cycle wake request |
| force_off_req | output | 1 | One-cycle unconditional soft-off request |
| press_sts | output | 1 | Sticky press status |
| btn_level | output | 1 | Filtered button level, 1 = pressed |

## Verification
The hardest situation to reach is a single hold that spans several power states and the stretch window. In that case the timer must restart on each return to running, and a wake must appear when the window closes rather than at the press edge. The bench keeps the button low while it changes `pwr_state` and `stretch_act` underneath it. It counts wake and force-off pulses with a monitor, and compares those counts at times placed safely before and after the expected hold length. Short filter and hold parameters keep these multi-state holds to a few hundred cycles.

// File: rtl/pbk_pkg.sv
package pbk_pkg;
   typedef enum logic [1:0] {
      PS_RUN     = 2'd0,
      PS_SLEEP   = 2'd1,
      PS_SOFTOFF = 2'd2,
      PS_MECHOFF = 2'd3
   } pbk_state_e;
endpackage

// File: rtl/pbk_filter.sv
module pbk_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_MS      = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_n,
   input  logic tick,
   output logic pressed
);
   localparam int CW = $clog2(DEB_MS + 1);
   localparam logic [CW-1:0] LAST = CW'(DEB_MS - 1);

   initial begin
      if (SYNC_STAGES < 2) $error("pbk_filter: SYNC_STAGES must be >= 2");
      if (DEB_MS < 1)      $error("pbk_filter: DEB_MS must be >= 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [CW-1:0]          cnt_q;
   logic                   samp;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[0] <= 1'b1;
               else        sync_q[0] <= raw_n;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sync_q[i] <= 1'b1;
               else        sync_q[i] <= sync_q[i-1];
         end
      end
   endgenerate

   assign samp = ~sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pressed <= 1'b0;
      end else if (samp == pressed) begin
         cnt_q <= '0;
      end else if (tick) begin
         if (cnt_q == LAST) begin
            pressed <= samp;
            cnt_q   <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pbk_hold_timer.sv
module pbk_hold_timer #(
   parameter int HOLD_MS = 4000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pressed,
   input  logic arm,
   input  logic tick,
   output logic fire
);
   localparam int CW = $clog2(HOLD_MS + 1);
   localparam logic [CW-1:0] LAST = CW'(HOLD_MS - 1);

   initial begin
      if (HOLD_MS < 2) $error("pbk_hold_timer: HOLD_MS must be >= 2");
   end

   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
         fire   <= 1'b0;
      end else begin
         fire <= 1'b0;
         if (!pressed || !arm) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
         end else if (tick && !done_q) begin
            if (cnt_q == LAST) begin
               fire   <= 1'b1;
               done_q <= 1'b1;
               cnt_q  <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pbk_router.sv
module pbk_router
   import pbk_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pressed,
   input  pbk_state_e state,
   input  logic       stretch,
   input  logic       sci_sel,
   input  logic       evt_en,
   input  logic       smi_glob_en,
   input  logic       sts_clr,
   output logic       sts,
   output logic       wake,
   output logic       sci_req,
   output logic       smi_req
);
   logic press_q, stretch_q;
   logic edge_hit, stretch_end, sleepy, run_hit, wake_hit, running;

   assign running     = (state == PS_RUN);
   assign sleepy      = (state == PS_SLEEP) || (state == PS_SOFTOFF);
   assign edge_hit    = pressed && !press_q;
   assign stretch_end = stretch_q && !stretch;
   assign run_hit     = running && edge_hit;
   assign wake_hit    = sleepy && !stretch && (edge_hit || (stretch_end && pressed));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         press_q   <= 1'b0;
         stretch_q <= 1'b0;
         sts       <= 1'b0;
         wake      <= 1'b0;
      end else begin
         press_q   <= pressed;
         stretch_q <= stretch;
         wake      <= wake_hit;
         if (run_hit || wake_hit) sts <= 1'b1;
         else if (sts_clr)        sts <= 1'b0;
      end
   end

   assign sci_req = running && sts && evt_en && sci_sel;
   assign smi_req = running && sts && evt_en && !sci_sel && smi_glob_en;
endmodule

// File: rtl/pwrkey_evt_ctl.sv
module pwrkey_evt_ctl
   import pbk_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_MS      = 16,
   parameter int HOLD_MS     = 4000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       btn_raw_n,
   input  logic       ms_tick,
   input  logic [1:0] pwr_state,
   input  logic       sci_sel,
   input  logic       evt_en,
   input  logic       smi_glob_en,
   input  logic       stretch_act,
   input  logic       sts_clr,
   output logic       sci_req,
   output logic       smi_req,
   output logic       wake_req,
   output logic       force_off_req,
   output logic       press_sts,
   output logic       btn_level
);
   initial begin
      if (HOLD_MS <= DEB_MS) $error("pwrkey_evt_ctl: HOLD_MS must exceed DEB_MS");
   end

   pbk_state_e st;
   logic       pressed, arm;

   assign st        = pbk_state_e'(pwr_state);
   assign arm       = (st == PS_RUN) && !stretch_act;
   assign btn_level = pressed;

   pbk_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_MS(DEB_MS)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_n(btn_raw_n), .tick(ms_tick), .pressed(pressed)
   );

   pbk_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold (
      .clk(clk), .rst_n(rst_n), .pressed(pressed), .arm(arm), .tick(ms_tick),
      .fire(force_off_req)
   );

   pbk_router u_rte (
      .clk(clk), .rst_n(rst_n), .pressed(pressed), .state(st), .stretch(stretch_act),
      .sci_sel(sci_sel), .evt_en(evt_en), .smi_glob_en(smi_glob_en), .sts_clr(sts_clr),
      .sts(press_sts), .wake(wake_req), .sci_req(sci_req), .smi_req(smi_req)
   );
endmodule

// File: rtl/pbk_checker.sv
module pbk_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ms_tick,
   input logic [1:0] pwr_state,
   input logic       evt_en,
   input logic       stretch_act,
   input logic       sci_req,
   input logic       smi_req,
   input logic       wake_req,
   input logic       force_off_req,
   input logic       press_sts,
   input logic       btn_level
);
   // R1: filtered level moves only on the cycle after a tick
   p_level_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(btn_level) |-> $past(ms_tick));

   // R4: the two interrupt requests never coexist and need status plus enable
   p_req_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(sci_req && smi_req));
   p_req_needs_sts_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sci_req || smi_req) |-> (press_sts && evt_en && pwr_state == 2'd0));

   // R5: wake is a single-cycle pulse
   p_wake_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |=> !wake_req);

   // R6: no wake out of mechanical-off
   p_no_wake_g3_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> $past(pwr_state) != 2'd3);

   // R7: force-off is a single-cycle pulse
   p_off_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      force_off_req |=> !force_off_req);

   // R8: force-off only after counting in running
   p_off_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
      force_off_req |-> ($past(pwr_state) == 2'd0 && $past(btn_level)));

   // R9: neither request is produced out of a stretch window
   p_wake_no_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> !$past(stretch_act));
   p_off_no_stretch_r9: assert property (@(posedge clk) disable iff (!rst_n)
      force_off_req |-> !$past(stretch_act));
endmodule

bind pwrkey_evt_ctl pbk_checker u_chk (
   .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_state(pwr_state), .evt_en(evt_en),
   .stretch_act(stretch_act), .sci_req(sci_req), .smi_req(smi_req), .wake_req(wake_req),
   .force_off_req(force_off_req), .press_sts(press_sts), .btn_level(btn_level)
);

// File: tb/sim_pwrkey_evt_ctl.sv
`timescale 1ns/1ps
module sim_pwrkey_evt_ctl;
   localparam int DEB  = 4;
   localparam int HOLD = 20;
   localparam int TDIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_raw_n = 1'b1, ms_tick = 1'b0;
   logic [1:0] pwr_state = 2'd0;
   logic sci_sel = 1'b0, evt_en = 1'b0, smi_glob_en = 1'b0, stretch_act = 1'b0, sts_clr = 1'b0;
   logic sci_req, smi_req, wake_req, force_off_req, press_sts, btn_level;

   int n_chk = 0, n_bad = 0, n_wake = 0, n_off = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   pwrkey_evt_ctl #(.DEB_MS(DEB), .HOLD_MS(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .btn_raw_n(btn_raw_n), .ms_tick(ms_tick),
      .pwr_state(pwr_state), .sci_sel(sci_sel), .evt_en(evt_en), .smi_glob_en(smi_glob_en),
      .stretch_act(stretch_act), .sts_clr(sts_clr), .sci_req(sci_req), .smi_req(smi_req),
      .wake_req(wake_req), .force_off_req(force_off_req), .press_sts(press_sts),
      .btn_level(btn_level)
   );

   // millisecond strobe and pulse monitor, both on the falling edge
   initial begin
      forever begin
         repeat (TDIV - 1) @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
      end
   end
   always @(negedge clk) begin
      if (rst_n && wake_req)      n_wake++;
      if (rst_n && force_off_req) n_off++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_ms(input int n);
      repeat (n * TDIV) @(negedge clk);
   endtask

   task automatic clear_sts();
      @(negedge clk); sts_clr = 1'b1;
      @(negedge clk); sts_clr = 1'b0;
   endtask

   // [8:7] state [6] sci_sel [5] evt_en [4] glob | [3] sts [2] sci [1] smi [0] wake
   localparam logic [8:0] VEC [8] = '{
      9'b00_110_1100, 9'b00_011_1010, 9'b00_010_1000, 9'b00_101_1000,
      9'b01_111_1001, 9'b10_011_1001, 9'b11_111_0000, 9'b00_001_1000
   };

   initial begin
      int w0, f0;
      repeat (5) @(negedge clk);
      chk(btn_level == 0 && press_sts == 0 && wake_req == 0 && force_off_req == 0 &&
          sci_req == 0 && smi_req == 0, "reset R2", {btn_level, press_sts}, 0);
      rst_n = 1'b1;
      wait_ms(2);

      // vector walk: R3 R4 R5 R6
      foreach (VEC[i]) begin
         w0 = n_wake;
         pwr_state = VEC[i][8:7]; sci_sel = VEC[i][6]; evt_en = VEC[i][5];
         smi_glob_en = VEC[i][4];
         btn_raw_n = 1'b0;
         wait_ms(DEB + 3);
         chk(press_sts == VEC[i][3], $sformatf("R3 vec%0d sts while held", i), press_sts, VEC[i][3]);
         chk(sci_req == VEC[i][2], $sformatf("R4 vec%0d sci", i), sci_req, VEC[i][2]);
         chk(smi_req == VEC[i][1], $sformatf("R4 vec%0d smi", i), smi_req, VEC[i][1]);
         btn_raw_n = 1'b1;
         wait_ms(DEB + 3);
         chk(n_wake - w0 == int'(VEC[i][0]), $sformatf("R5/R6 vec%0d wakes", i), n_wake - w0, VEC[i][0]);
         clear_sts();
         @(negedge clk);
         chk(press_sts == 0 && sci_req == 0 && smi_req == 0, "R3 clear", press_sts, 0);
      end
      chk(n_off == 0, "R7 no override on short presses", n_off, 0);

      // R1: glitch shorter than filter
      pwr_state = 2'd0; sci_sel = 1'b1; evt_en = 1'b1;
      btn_raw_n = 1'b0; wait_ms(DEB - 2); btn_raw_n = 1'b1;
      wait_ms(DEB + 2);
      chk(btn_level == 0 && press_sts == 0, "R1 glitch ignored", press_sts, 0);

      // R2: level follows filtered button
      btn_raw_n = 1'b0; wait_ms(DEB + 2);
      chk(btn_level == 1, "R2 level pressed", btn_level, 1);
      btn_raw_n = 1'b1; wait_ms(DEB + 2);
      chk(btn_level == 0, "R2 level released", btn_level, 0);
      clear_sts();

      // R7: override in running, once per hold
      f0 = n_off;
      btn_raw_n = 1'b0; wait_ms(HOLD);
      chk(n_off == f0, "R7 not before hold time", n_off - f0, 0);
      wait_ms(10);
      chk(n_off == f0 + 1, "R7 override fired", n_off - f0, 1);
      wait_ms(HOLD + 5);
      chk(n_off == f0 + 1, "R7 only once per hold", n_off - f0, 1);
      btn_raw_n = 1'b1; wait_ms(DEB + 2); clear_sts();

      // R8: hold starting in sleep
      f0 = n_off; w0 = n_wake;
      pwr_state = 2'd1; btn_raw_n = 1'b0; wait_ms(DEB + 3);
      chk(n_wake == w0 + 1, "R8 wake from sleep", n_wake - w0, 1);
      wait_ms(HOLD + 10);
      chk(n_off == f0, "R8 no count in sleep", n_off - f0, 0);
      pwr_state = 2'd0; wait_ms(HOLD - 5);
      chk(n_off == f0, "R8 restart on resume", n_off - f0, 0);
      wait_ms(8);
      chk(n_off == f0 + 1, "R8 override after resume", n_off - f0, 1);
      btn_raw_n = 1'b1; wait_ms(DEB + 2); clear_sts();

      // R9: stretch in soft-off suppresses wake until it ends
      w0 = n_wake;
      pwr_state = 2'd2; stretch_act = 1'b1; btn_raw_n = 1'b0; wait_ms(DEB + 6);
      chk(n_wake == w0 && press_sts == 0, "R9 no wake in stretch", n_wake - w0, 0);
      stretch_act = 1'b0; wait_ms(1);
      chk(n_wake == w0 + 1, "R9 wake at stretch end", n_wake - w0, 1);
      // R9: stretch in running holds timer at zero
      f0 = n_off;
      pwr_state = 2'd0; stretch_act = 1'b1; wait_ms(HOLD + 10);
      chk(n_off == f0, "R9 timer held in stretch", n_off - f0, 0);
      stretch_act = 1'b0; wait_ms(HOLD - 5);
      chk(n_off == f0, "R9 fresh hold needed", n_off - f0, 0);
      wait_ms(8);
      chk(n_off == f0 + 1, "R9 override after fresh hold", n_off - f0, 1);
      btn_raw_n = 1'b1; wait_ms(DEB + 2); clear_sts();

      // R6: long hold in mechanical-off
      w0 = n_wake; f0 = n_off;
      pwr_state = 2'd3; btn_raw_n = 1'b0; wait_ms(HOLD + 10);
      chk(n_wake == w0 && n_off == f0 && press_sts == 0, "R6 G3 long hold inert",
          n_wake - w0 + n_off - f0, 0);
      btn_raw_n = 1'b1; wait_ms(DEB + 2);

      // R3: set wins over a simultaneous clear is not timed here; clear after set
      pwr_state = 2'd0; btn_raw_n = 1'b0; wait_ms(DEB + 3);
      sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0; @(negedge clk);
      chk(press_sts == 0, "R3 clear while still held", press_sts, 0);
      btn_raw_n = 1'b1; wait_ms(DEB + 2);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(negedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule